// File: doc/BRIEF.md
# Password Unlock Security Controller

This block guards a region of protected memory behind a 128-bit password. The password is held in eight 16-bit storage words, which a loader port fills. Software reads every password word once, with reads whose data it discards. It then writes a 128-bit key as eight 16-bit words through a small register bus. The block compares the key with the stored password and raises one of two grants. A full grant requires a match on all 128 bits. A debug grant requires a match on only the lower 64 bits, and it permits stepping through secure code.

A trip detector watches accesses to the protected region. If such an access occurs while a debugger is attached and the debug grant is not held, the block raises a trip flag. The trip flag tells the surrounding logic to sever the debug connection, and it stays set until reset. Two password values are handled specially. A password of all ones counts as unprogrammed and leaves the part open. A password of all zeros is a permanent lock.

Top module: `pwd_unlock_top`

## Requirements
- R1: During and straight after reset, `fullUnlock`, `dbgUnlock` and `dbgTrip` are 0, and the key words reset to zero.
- R2: No grant is given until all eight password words have been read since the last key write. Seven distinct reads are not enough.
- R3: When all eight words have been read and the eight key words equal the stored password, `fullUnlock` and `dbgUnlock` are 1 one cycle after the last read or key write. Key word i holds bits [16i+15:16i], and so does password word i.
- R4: If only key words 0..3 (bits 63:0) match the stored password and all eight words have been read, `dbgUnlock` is 1 and `fullUnlock` is 0.
- R5: If password bits 63:0 are all ones and all eight words have been read, `dbgUnlock` is 1 whatever the key holds. Before those reads it stays 0.
- R6: A stored password of all ones sets both grants one cycle after reset ends, with no key and no reads.
- R7: A stored password of all zeros never sets either grant, not even with an all-zero key and all eight reads done.
- R8: Any key word write clears the read tracker, so the grants drop one cycle later and need eight fresh reads.
- R9: An access to protected memory (`memAccess`) while `dbgAttached` is 1 and `dbgUnlock` is 0 sets `dbgTrip` one cycle later. The access sets no trip when the debugger is detached or the debug grant is held.
- R10: Once set, `dbgTrip` stays 1 until reset, even after a later unlock.
- R11: Bus address bit 3 selects the target: 0 selects password word `busAddr[2:0]`, 1 selects key word `busAddr[2:0]`. A read counts toward the tracker only when it targets a password word. A key word changes only on a write to a key address. A write to a password address has no effect, and a read of a key address counts for nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwdLoadEn | input | 1 | Writes one password storage word |
| pwdLoadIdx | input | 3 | Password word index for the loader |
| pwdLoadData | input | 16 | Password word value for the loader |
| busEn | input | 1 | Register bus transfer valid |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 4 | Bit 3 selects key (1) or password (0); bits 2:0 select the word |
| busWData | input | 16 | Key word write data |
| memAccess | input | 1 | Code or data access to protected memory this cycle |
| dbgAttached | input | 1 | Debugger connected |
| fullUnlock | output | 1 | Full access granted |
| dbgUnlock | output | 1 | Debug stepping of secure code granted |
| dbgTrip | output | 1 | Sticky request to cut the debug connection |

## Verification
Every bus transfer updates the key words or the read tracker on the clock edge where it is presented. Both grants are registered from that state, so each grant is due one cycle after the transfer that completes it. Likewise, a key write removes the grants one cycle later, and a qualifying access sets `dbgTrip` on the edge after the access. The bench drives inputs at falling edges and holds each transfer for exactly one rising edge. It then samples the outputs at the next falling edge, which falls after the edge where the result registers.

// File: rtl/pwd_unlock_pkg.sv
package pwd_unlock_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic keyWr;
    logic pwdRd;
  } ctlStrobes_t;

  // Comparator results from the datapath
  typedef struct packed {
    logic fullMatch;
    logic loMatch;
    logic pwdBlank;
    logic loBlank;
    logic pwdZero;
  } dpStatus_t;

endpackage

// File: rtl/pwd_datapath.sv
module pwd_datapath
  import pwd_unlock_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwdLoadEn,
  input  logic [IDX_W-1:0]  pwdLoadIdx,
  input  logic [WORD_W-1:0] pwdLoadData,
  input  ctlStrobes_t       strobes,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [WORD_W-1:0] wrData,
  output dpStatus_t         status
);

  localparam int TOTAL_W = NUM_WORDS * WORD_W;
  localparam int LO_W    = (NUM_WORDS / 2) * WORD_W;

  logic [TOTAL_W-1:0] pwdFlat;
  logic [TOTAL_W-1:0] keyFlat;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    // password storage: loader-filled, no reset
    always_ff @(posedge clk) begin
      if (pwdLoadEn && pwdLoadIdx == IDX_W'(g))
        pwdFlat[g*WORD_W +: WORD_W] <= pwdLoadData;
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        keyFlat[g*WORD_W +: WORD_W] <= '0;
      else if (strobes.keyWr && wordIdx == IDX_W'(g))
        keyFlat[g*WORD_W +: WORD_W] <= wrData;
    end
  end

  always_comb begin
    status.fullMatch = (keyFlat == pwdFlat);
    status.loMatch   = (keyFlat[LO_W-1:0] == pwdFlat[LO_W-1:0]);
    status.pwdBlank  = &pwdFlat;
    status.loBlank   = &pwdFlat[LO_W-1:0];
    status.pwdZero   = ~|pwdFlat;
  end

  // R3
  key_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.keyWr |=> keyFlat[$past(wordIdx)*WORD_W +: WORD_W] == $past(wrData));

  // R11
  key_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.keyWr |=> $stable(keyFlat));

endmodule

// File: rtl/pwd_control.sv
module pwd_control
  import pwd_unlock_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busEn,
  input  logic             busWr,
  input  logic [IDX_W:0]   busAddr,
  input  logic             memAccess,
  input  logic             dbgAttached,
  input  dpStatus_t        status,
  output ctlStrobes_t      strobes,
  output logic [IDX_W-1:0] wordIdx,
  output logic             fullUnlock,
  output logic             dbgUnlock,
  output logic             dbgTrip
);

  logic [NUM_WORDS-1:0] readSeen;
  logic allRead;
  logic fullNext;
  logic dbgNext;
  logic tripHit;

  assign wordIdx = busAddr[IDX_W-1:0];

  always_comb begin
    strobes.keyWr = busEn && busWr && busAddr[IDX_W];
    strobes.pwdRd = busEn && !busWr && !busAddr[IDX_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      readSeen <= '0;
    else if (strobes.keyWr)
      readSeen <= '0;
    else if (strobes.pwdRd)
      readSeen[wordIdx] <= 1'b1;
  end

  assign allRead  = &readSeen;
  assign fullNext = !status.pwdZero &&
                    (status.pwdBlank || (allRead && status.fullMatch));
  assign dbgNext  = fullNext ||
                    (!status.pwdZero && allRead && (status.loMatch || status.loBlank));
  assign tripHit  = memAccess && dbgAttached && !dbgUnlock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullUnlock <= 1'b0;
      dbgUnlock  <= 1'b0;
      dbgTrip    <= 1'b0;
    end else begin
      fullUnlock <= fullNext;
      dbgUnlock  <= dbgNext;
      dbgTrip    <= dbgTrip || tripHit;
    end
  end

  // R8
  tracker_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.keyWr |=> readSeen == '0);

  // R2
  reads_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullUnlock && !$past(status.pwdBlank) |-> $past(allRead));

  // R7
  zero_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgUnlock |-> !$past(status.pwdZero));

  // R10
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgTrip |=> dbgTrip);

  // R9
  trip_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgTrip) |-> $past(memAccess && dbgAttached && !dbgUnlock));

endmodule

// File: rtl/pwd_unlock_top.sv
module pwd_unlock_top
  import pwd_unlock_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwdLoadEn,
  input  logic [IDX_W-1:0]  pwdLoadIdx,
  input  logic [WORD_W-1:0] pwdLoadData,
  input  logic              busEn,
  input  logic              busWr,
  input  logic [IDX_W:0]    busAddr,
  input  logic [WORD_W-1:0] busWData,
  input  logic              memAccess,
  input  logic              dbgAttached,
  output logic              fullUnlock,
  output logic              dbgUnlock,
  output logic              dbgTrip
);

  ctlStrobes_t      strobes;
  dpStatus_t        status;
  logic [IDX_W-1:0] wordIdx;

  pwd_control #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .memAccess(memAccess), .dbgAttached(dbgAttached), .status(status),
    .strobes(strobes), .wordIdx(wordIdx), .fullUnlock(fullUnlock),
    .dbgUnlock(dbgUnlock), .dbgTrip(dbgTrip)
  );

  pwd_datapath #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .pwdLoadEn(pwdLoadEn), .pwdLoadIdx(pwdLoadIdx),
    .pwdLoadData(pwdLoadData), .strobes(strobes), .wordIdx(wordIdx),
    .wrData(busWData), .status(status)
  );

endmodule

// File: tb/pwd_unlock_top_tb.sv
module pwd_unlock_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwdLoadEn = 1'b0;
  logic [2:0] pwdLoadIdx = '0;
  logic [15:0] pwdLoadData = '0;
  logic busEn = 1'b0;
  logic busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [15:0] busWData = '0;
  logic memAccess = 1'b0;
  logic dbgAttached = 1'b0;
  logic fullUnlock, dbgUnlock, dbgTrip;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [127:0] PWD = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  always #4 clk = ~clk;

  pwd_unlock_top u_dut (
    .clk(clk), .rstN(rstN), .pwdLoadEn(pwdLoadEn), .pwdLoadIdx(pwdLoadIdx),
    .pwdLoadData(pwdLoadData), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .memAccess(memAccess), .dbgAttached(dbgAttached),
    .fullUnlock(fullUnlock), .dbgUnlock(dbgUnlock), .dbgTrip(dbgTrip)
  );

  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic checkFlags(string tag, logic f, logic d, logic t);
    checkBit({tag, " fullUnlock"}, fullUnlock, f);
    checkBit({tag, " dbgUnlock"}, dbgUnlock, d);
    checkBit({tag, " dbgTrip"}, dbgTrip, t);
  endtask

  // reset with password preloaded while reset is held
  task automatic doReset(logic [127:0] pw);
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      pwdLoadEn = 1'b1;
      pwdLoadIdx = 3'(i);
      pwdLoadData = pw[i*16 +: 16];
      @(negedge clk);
    end
    pwdLoadEn = 1'b0;
    rstN = 1'b1;
  endtask

  task automatic busOp(logic wr, logic [3:0] addr, logic [15:0] data);
    busEn = 1'b1; busWr = wr; busAddr = addr; busWData = data;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
  endtask

  task automatic readWords(int n);
    for (int i = 0; i < n; i++) busOp(1'b0, 4'(i), 16'h0);
  endtask

  task automatic writeKey(logic [127:0] k);
    for (int i = 0; i < 8; i++) busOp(1'b1, 4'(8 + i), k[i*16 +: 16]);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset(PWD);
    rstN = 1'b0;
    settle();
    checkFlags("R1 in reset", 0, 0, 0);
    rstN = 1'b1;
    settle();
    checkFlags("R1 after reset", 0, 0, 0);
    readWords(8);
    settle();
    checkFlags("R1 zero key after reads", 0, 0, 0);
  endtask

  task automatic testFull();
    doReset(PWD);
    writeKey(PWD);
    readWords(7);
    settle();
    checkFlags("R2 seven reads", 0, 0, 0);
    busOp(1'b0, 4'd7, 16'h0);
    checkBit("R3 not before edge", fullUnlock, 1'b0);
    settle();
    checkFlags("R3 full match", 1, 1, 0);
  endtask

  task automatic testRewrite();
    doReset(PWD);
    readWords(8);
    writeKey(PWD);
    settle();
    checkFlags("R8 reads before key", 0, 0, 0);
    readWords(8);
    settle();
    checkFlags("R8 fresh reads", 1, 1, 0);
    busOp(1'b1, 4'd8, PWD[15:0]);
    settle();
    checkFlags("R8 same-value rewrite", 0, 0, 0);
  endtask

  task automatic testDebug();
    doReset(PWD);
    writeKey({~PWD[127:64], PWD[63:0]});
    readWords(8);
    settle();
    checkFlags("R4 lower match only", 0, 1, 0);
    doReset(PWD);
    writeKey({PWD[127:64], ~PWD[63:0]});
    readWords(8);
    settle();
    checkFlags("R4 upper match only", 0, 0, 0);
  endtask

  task automatic testLoBlank();
    doReset({PWD[127:64], 64'hFFFF_FFFF_FFFF_FFFF});
    settle();
    checkFlags("R5 no reads", 0, 0, 0);
    readWords(8);
    settle();
    checkFlags("R5 blank lower", 0, 1, 0);
  endtask

  task automatic testBlank();
    doReset('1);
    settle();
    checkFlags("R6 all ones", 1, 1, 0);
  endtask

  task automatic testZero();
    doReset('0);
    writeKey('0);
    readWords(8);
    settle();
    checkFlags("R7 all zeros", 0, 0, 0);
  endtask

  task automatic testAddr();
    doReset(PWD);
    writeKey(PWD);
    readWords(8);
    settle();
    checkFlags("R11 baseline", 1, 1, 0);
    busOp(1'b1, 4'd0, 16'hDEAD);
    settle();
    checkFlags("R11 write to password addr", 1, 1, 0);
    doReset(PWD);
    writeKey(PWD);
    readWords(7);
    busOp(1'b0, 4'd15, 16'h0);
    settle();
    checkFlags("R11 key read not counted", 0, 0, 0);
  endtask

  task automatic testTrip();
    doReset(PWD);
    memAccess = 1'b1; dbgAttached = 1'b0;
    settle();
    memAccess = 1'b0;
    settle();
    checkFlags("R9 detached access", 0, 0, 0);
    memAccess = 1'b1; dbgAttached = 1'b1;
    settle();
    memAccess = 1'b0;
    checkBit("R9 trip set", dbgTrip, 1'b1);
    writeKey(PWD);
    readWords(8);
    settle();
    checkFlags("R10 trip sticky after unlock", 1, 1, 1);
    doReset(PWD);
    writeKey({~PWD[127:64], PWD[63:0]});
    readWords(8);
    settle();
    memAccess = 1'b1;
    settle();
    memAccess = 1'b0;
    settle();
    checkFlags("R9 debug unlocked access", 0, 1, 0);
    dbgAttached = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testFull();
    testRewrite();
    testDebug();
    testLoBlank();
    testBlank();
    testZero();
    testAddr();
    testTrip();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule